// File: doc/BRIEF.md
# Packed SIMD Conversion Fault Classifier

This block sits beside the issue logic of a packed floating-point to integer conversion unit. Each cycle a request may present everything needed to decide whether the instruction must fault:
- the processor control state and the feature flag;
- the lock prefix indicator;
- the operating mode;
- the memory operand's address, together with the segment and page-walk verdicts supplied by other units;
- the unmasked floating-point exception status reported by the datapath.

One cycle later the block returns a single fault as a one-hot vector with a fault-present bit. The vector can also be empty.

The faults are ranked in a fixed order:
1. Encoding and enable problems.
2. The device-unavailable condition.
3. Address and alignment problems of the memory operand.
4. A page fault.
5. The datapath floating-point condition.

For that last condition, the operating system enable bit decides whether it reports as a SIMD floating-point fault or as an invalid-opcode fault. The address checks depend on the mode. Real mode bounds a 16-bit offset. Protected and compatibility modes use the segment verdict. 64-bit mode checks the address for canonical form.

Top module: `simd_fault_classifier`

## Requirements
- R1: A request accepted on a clock edge (`req_vld`=1) produces `rsp_vld`=1 with its fault vector right after the next edge. A cycle without a request leaves `rsp_vld`, `flt_vld` and `flt_vec` at 0 after that edge. Reset clears all three outputs.
- R2: `flt_vec` bit 0 is invalid-opcode, bit 1 is device-unavailable, bit 2 is general-protection, bit 3 is stack fault, bit 4 is page fault and bit 5 is SIMD floating-point. At most one bit is set, and `flt_vld` is 1 exactly when a bit is set.
- R3: Any of the following gives invalid-opcode, ahead of every other fault: `lock_pfx`=1, `fpu_emul`=1, `fxsave_os_en`=0 or `simd_ext_ok`=0.
- R4: `ctx_switched`=1 gives device-unavailable. It ranks below R3 and above every memory or floating-point fault.
- R5: With `mem_use`=1, an address whose low 4 bits are not zero gives general-protection in every mode. This applies regardless of the segment.
- R6: In real mode (`cpu_mode`=0), an operand whose last byte lies beyond offset 0xFFFF gives general-protection. The offset is address bits 15:0, and the operand is 16 bytes. In real mode, `seg_limit_fail`, `seg_stack`, `pf_hit` and address bits 63:16 have no effect.
- R7: In protected mode (`cpu_mode`=1) or compatibility mode (`cpu_mode`=3), `seg_limit_fail`=1 gives a stack fault when `seg_stack`=1 and general-protection otherwise. The canonical form of the address has no effect in these modes.
- R8: In 64-bit mode (`cpu_mode`=2), an address with bits 63:47 not all equal gives a stack fault when `seg_stack`=1 and general-protection otherwise. `seg_limit_fail` has no effect in this mode.
- R9: The mode's address check of R6 to R8 is evaluated before the alignment check. So a stack-segment address fault on a misaligned address reports a stack fault.
- R10: Outside real mode, `pf_hit`=1 with `mem_use`=1 gives a page fault, but only when no R3 to R9 fault applies.
- R11: `fp_unmasked`=1 is the lowest-ranked fault. It reports SIMD floating-point when `simd_exc_os_en`=1 and invalid-opcode when it is 0.
- R12: With `mem_use`=0, none of `mem_addr`, `seg_stack`, `seg_limit_fail` and `pf_hit` has any effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | A classification request is present this cycle |
| ctx_switched | input | 1 | Task-switched control flag |
| fpu_emul | input | 1 | Floating-point emulation control flag |
| fxsave_os_en | input | 1 | OS support for extended state save is enabled |
| simd_exc_os_en | input | 1 | OS handles unmasked SIMD floating-point exceptions |
| simd_ext_ok | input | 1 | The processor supports the packed double-precision extension |
| lock_pfx | input | 1 | The instruction carries a lock prefix |
| cpu_mode | input | 2 | 0 real, 1 protected, 2 64-bit, 3 compatibility |
| mem_use | input | 1 | The source operand is in memory |
| mem_addr | input | 64 | Effective address of the memory operand |
| seg_stack | input | 1 | The operand references the stack segment |
| seg_limit_fail | input | 1 | Segment check verdict from the segment unit |
| pf_hit | input | 1 | Page walk reported a fault for the operand |
| fp_unmasked | input | 1 | The datapath raised an unmasked floating-point exception |
| rsp_vld | output | 1 | The response to last cycle's request is present |
| flt_vld | output | 1 | The response carries a fault |
| flt_vec | output | 6 | One-hot fault vector |

## Verification
The situation hardest to reach from the ports is a single request in which several fault sources are true together. This is the only case where the ranking, rather than any one rule, decides the answer. An example is a stack-segment address fault on a misaligned address that also has a page fault and an unmasked floating-point exception.

Directed steps build these stacks one layer at a time, removing the highest-ranked cause each time. They also place addresses exactly on the canonical and real-mode boundaries. A long stream of biased random requests then covers mixed combinations in every mode.

// File: rtl/simd_flt_pkg.sv
package simd_flt_pkg;

  localparam int ADDR_W = 64;
  localparam int FLT_N  = 6;

  localparam int FLT_INVOP = 0;
  localparam int FLT_NODEV = 1;
  localparam int FLT_GPROT = 2;
  localparam int FLT_STACK = 3;
  localparam int FLT_PAGE  = 4;
  localparam int FLT_SIMD  = 5;

  typedef logic [FLT_N-1:0] flt_vec_t;

  typedef enum logic [1:0] {
    MODE_REAL   = 2'd0,
    MODE_PROT   = 2'd1,
    MODE_LONG   = 2'd2,
    MODE_COMPAT = 2'd3
  } cpu_mode_e;

  // Bits at and above the implemented width must copy the top implemented bit.
  function automatic logic addr_canonical(input logic [ADDR_W-1:0] a,
                                          input int unsigned va_bits);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < ADDR_W; i++) begin
      if (i >= int'(va_bits) && a[i] != a[va_bits-1]) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic addr_aligned(input logic [ADDR_W-1:0] a,
                                        input int unsigned nbytes);
    logic [ADDR_W-1:0] msk;
    msk = ADDR_W'(nbytes - 1);
    return (a & msk) == '0;
  endfunction

  // Last byte of the operand past the 16-bit offset limit.
  function automatic logic real_beyond(input logic [ADDR_W-1:0] a,
                                       input int unsigned nbytes,
                                       input int unsigned limit);
    logic [16:0] last_byte;
    last_byte = {1'b0, a[15:0]} + 17'(nbytes - 1);
    return last_byte > 17'(limit);
  endfunction

endpackage

// File: rtl/sfc_enable_chk.sv
module sfc_enable_chk (
  input  logic fpu_emul,
  input  logic fxsave_os_en,
  input  logic simd_ext_ok,
  input  logic lock_pfx,
  input  logic ctx_switched,
  output logic enc_ud,
  output logic dev_na
);
  always_comb begin
    enc_ud = lock_pfx | fpu_emul | ~fxsave_os_en | ~simd_ext_ok;
    dev_na = ctx_switched;
  end
endmodule

// File: rtl/sfc_mem_chk.sv
module sfc_mem_chk
  import simd_flt_pkg::*;
#(
  parameter int unsigned VA_BITS    = 48,
  parameter int unsigned OPND_BYTES = 16,
  parameter int unsigned REAL_LIMIT = 65535
) (
  input  logic [1:0]        cpu_mode,
  input  logic              mem_use,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              seg_stack,
  input  logic              seg_limit_fail,
  input  logic              pf_hit,
  output logic              addr_fault,
  output logic              align_fault,
  output logic              mem_gp,
  output logic              mem_ss,
  output logic              mem_pf
);
  logic real_bad, canon_bad, mis_al;
  logic addr_fail, stack_sel, pf_ok;

  always_comb begin
    real_bad  = real_beyond(mem_addr, OPND_BYTES, REAL_LIMIT);
    canon_bad = ~addr_canonical(mem_addr, VA_BITS);
    mis_al    = ~addr_aligned(mem_addr, OPND_BYTES);
  end

  always_comb begin
    case (cpu_mode_e'(cpu_mode))
      MODE_REAL: begin
        addr_fail = real_bad;
        stack_sel = 1'b0;
        pf_ok     = 1'b0;
      end
      MODE_LONG: begin
        addr_fail = canon_bad;
        stack_sel = seg_stack;
        pf_ok     = 1'b1;
      end
      default: begin
        addr_fail = seg_limit_fail;
        stack_sel = seg_stack;
        pf_ok     = 1'b1;
      end
    endcase
  end

  always_comb begin
    addr_fault  = mem_use & addr_fail;
    align_fault = mem_use & mis_al;
    mem_ss      = addr_fault & stack_sel;
    mem_gp      = addr_fault ? ~stack_sel : align_fault;
    mem_pf      = mem_use & pf_ok & pf_hit;
  end
endmodule

// File: rtl/sfc_prio.sv
module sfc_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  for (genvar i = 0; i < N; i++) begin : g_rank
    if (i == 0) begin : g_top
      assign gnt[i] = req[i];
    end else begin : g_low
      assign gnt[i] = req[i] & ~(|req[i-1:0]);
    end
  end
endmodule

// File: rtl/simd_fault_classifier.sv
module simd_fault_classifier
  import simd_flt_pkg::*;
#(
  parameter int unsigned VA_BITS    = 48,
  parameter int unsigned OPND_BYTES = 16,
  parameter int unsigned REAL_LIMIT = 65535
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_vld,
  input  logic                   ctx_switched,
  input  logic                   fpu_emul,
  input  logic                   fxsave_os_en,
  input  logic                   simd_exc_os_en,
  input  logic                   simd_ext_ok,
  input  logic                   lock_pfx,
  input  logic [1:0]             cpu_mode,
  input  logic                   mem_use,
  input  logic [ADDR_W-1:0]      mem_addr,
  input  logic                   seg_stack,
  input  logic                   seg_limit_fail,
  input  logic                   pf_hit,
  input  logic                   fp_unmasked,
  output logic                   rsp_vld,
  output logic                   flt_vld,
  output logic [FLT_N-1:0]       flt_vec
);
  localparam int RANK_N   = 5;
  localparam int RK_ENC   = 0;
  localparam int RK_DEV   = 1;
  localparam int RK_ADDR  = 2;
  localparam int RK_PAGE  = 3;
  localparam int RK_FP    = 4;

  logic enc_ud, dev_na;
  logic addr_fault, align_fault, mem_gp, mem_ss, mem_pf;
  logic mem_any;
  logic [RANK_N-1:0] rank_req, rank_gnt;
  flt_vec_t nxt_vec;

  sfc_enable_chk u_en (
    .fpu_emul     (fpu_emul),
    .fxsave_os_en (fxsave_os_en),
    .simd_ext_ok  (simd_ext_ok),
    .lock_pfx     (lock_pfx),
    .ctx_switched (ctx_switched),
    .enc_ud       (enc_ud),
    .dev_na       (dev_na)
  );

  sfc_mem_chk #(
    .VA_BITS    (VA_BITS),
    .OPND_BYTES (OPND_BYTES),
    .REAL_LIMIT (REAL_LIMIT)
  ) u_mem (
    .cpu_mode       (cpu_mode),
    .mem_use        (mem_use),
    .mem_addr       (mem_addr),
    .seg_stack      (seg_stack),
    .seg_limit_fail (seg_limit_fail),
    .pf_hit         (pf_hit),
    .addr_fault     (addr_fault),
    .align_fault    (align_fault),
    .mem_gp         (mem_gp),
    .mem_ss         (mem_ss),
    .mem_pf         (mem_pf)
  );

  assign mem_any = mem_gp | mem_ss | mem_pf;

  always_comb begin
    rank_req          = '0;
    rank_req[RK_ENC]  = enc_ud;
    rank_req[RK_DEV]  = dev_na;
    rank_req[RK_ADDR] = mem_gp | mem_ss;
    rank_req[RK_PAGE] = mem_pf;
    rank_req[RK_FP]   = fp_unmasked;
  end

  sfc_prio #(.N(RANK_N)) u_prio (
    .req (rank_req),
    .gnt (rank_gnt)
  );

  // Map the winning rank to the architectural fault bit.
  always_comb begin
    nxt_vec            = '0;
    nxt_vec[FLT_INVOP] = rank_gnt[RK_ENC] | (rank_gnt[RK_FP] & ~simd_exc_os_en);
    nxt_vec[FLT_NODEV] = rank_gnt[RK_DEV];
    nxt_vec[FLT_GPROT] = rank_gnt[RK_ADDR] & mem_gp;
    nxt_vec[FLT_STACK] = rank_gnt[RK_ADDR] & mem_ss;
    nxt_vec[FLT_PAGE]  = rank_gnt[RK_PAGE];
    nxt_vec[FLT_SIMD]  = rank_gnt[RK_FP] & simd_exc_os_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld <= 1'b0;
      flt_vld <= 1'b0;
      flt_vec <= '0;
    end else begin
      rsp_vld <= req_vld;
      flt_vld <= req_vld & (|nxt_vec);
      flt_vec <= req_vld ? nxt_vec : '0;
    end
  end
endmodule

// File: rtl/simd_fault_classifier_chk.sv
module simd_fault_classifier_chk
  import simd_flt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_vld,
  input logic             lock_pfx,
  input logic             ctx_switched,
  input logic             fp_unmasked,
  input logic             simd_exc_os_en,
  input logic             enc_ud,
  input logic             mem_any,
  input logic             rsp_vld,
  input logic             flt_vld,
  input logic [FLT_N-1:0] flt_vec
);
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!rsp_vld && !flt_vld && flt_vec == '0));

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flt_vec));

  a_r2_vld_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    flt_vld |-> (rsp_vld && $countones(flt_vec) == 1));

  a_r3_lock_invop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && lock_pfx) |=> flt_vec == FLT_N'(1 << FLT_INVOP));

  a_r4_nodev_rank: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !enc_ud && ctx_switched) |=> flt_vec == FLT_N'(1 << FLT_NODEV));

  a_r11_simd_last: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !enc_ud && !ctx_switched && !mem_any && fp_unmasked && simd_exc_os_en)
      |=> flt_vec == FLT_N'(1 << FLT_SIMD));

  a_r11_quiet_when_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !enc_ud && !ctx_switched && !mem_any && !fp_unmasked) |=> !flt_vld);
endmodule

bind simd_fault_classifier simd_fault_classifier_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_vld        (req_vld),
  .lock_pfx       (lock_pfx),
  .ctx_switched   (ctx_switched),
  .fp_unmasked    (fp_unmasked),
  .simd_exc_os_en (simd_exc_os_en),
  .enc_ud         (enc_ud),
  .mem_any        (mem_any),
  .rsp_vld        (rsp_vld),
  .flt_vld        (flt_vld),
  .flt_vec        (flt_vec)
);

// File: tb/simd_fault_classifier_tb.sv
`timescale 1ns/1ps
module simd_fault_classifier_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0, ctx_switched = 1'b0, fpu_emul = 1'b0;
  logic        fxsave_os_en = 1'b1, simd_exc_os_en = 1'b1, simd_ext_ok = 1'b1;
  logic        lock_pfx = 1'b0, mem_use = 1'b0, seg_stack = 1'b0;
  logic        seg_limit_fail = 1'b0, pf_hit = 1'b0, fp_unmasked = 1'b0;
  logic [1:0]  cpu_mode = 2'd1;
  logic [63:0] mem_addr = 64'h0;
  logic        rsp_vld, flt_vld;
  logic [5:0]  flt_vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic       exp_have = 1'b0;
  logic       exp_rsp;
  logic [5:0] exp_vec;
  string      exp_tag;

  always #2 clk = ~clk;

  simd_fault_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .ctx_switched(ctx_switched),
    .fpu_emul(fpu_emul), .fxsave_os_en(fxsave_os_en), .simd_exc_os_en(simd_exc_os_en),
    .simd_ext_ok(simd_ext_ok), .lock_pfx(lock_pfx), .cpu_mode(cpu_mode),
    .mem_use(mem_use), .mem_addr(mem_addr), .seg_stack(seg_stack),
    .seg_limit_fail(seg_limit_fail), .pf_hit(pf_hit), .fp_unmasked(fp_unmasked),
    .rsp_vld(rsp_vld), .flt_vld(flt_vld), .flt_vec(flt_vec)
  );

  // Reference: returns the fault bit index (-1 for none) and the rule that decided it.
  function automatic int ref_fault(output string why);
    logic [16:0] hi;
    bit          bad;
    why = "R11";
    if (lock_pfx || fpu_emul || !fxsave_os_en || !simd_ext_ok) begin why = "R3"; return 0; end
    if (ctx_switched) begin why = "R4"; return 1; end
    if (mem_use) begin
      hi = mem_addr[63:47];
      if (cpu_mode == 2'd0)      begin bad = (mem_addr[15:0] > 16'hFFF0); why = "R6"; end
      else if (cpu_mode == 2'd2) begin bad = !(hi == 17'h0 || hi == 17'h1FFFF); why = "R8"; end
      else                       begin bad = seg_limit_fail; why = "R7"; end
      if (bad) return (cpu_mode != 2'd0 && seg_stack) ? 3 : 2;
      if (mem_addr[3:0] != 4'h0) begin why = "R5"; return 2; end
      if (cpu_mode != 2'd0 && pf_hit) begin why = "R10"; return 4; end
    end
    if (fp_unmasked) begin why = "R11"; return simd_exc_os_en ? 5 : 0; end
    why = mem_use ? "R12" : "R2";
    return -1;
  endfunction

  task automatic compare_prev();
    if (exp_have) begin
      checks++;
      if (rsp_vld !== exp_rsp || flt_vec !== exp_vec || flt_vld !== (exp_vec != 6'd0)) begin
        errors++;
        $display("FAIL %s actual rsp=%b vld=%b vec=%b expected rsp=%b vld=%b vec=%b",
                 exp_tag, rsp_vld, flt_vld, flt_vec, exp_rsp, (exp_vec != 6'd0), exp_vec);
      end
    end
  endtask

  task automatic step(input string tag, input logic v, input logic ts, input logic em,
                      input logic fx, input logic xe, input logic s2, input logic lk,
                      input logic [1:0] md, input logic mu, input logic [63:0] ad,
                      input logic st, input logic sl, input logic pf, input logic fp);
    int    c;
    string why;
    @(negedge clk);
    compare_prev();
    req_vld = v; ctx_switched = ts; fpu_emul = em; fxsave_os_en = fx;
    simd_exc_os_en = xe; simd_ext_ok = s2; lock_pfx = lk; cpu_mode = md;
    mem_use = mu; mem_addr = ad; seg_stack = st; seg_limit_fail = sl;
    pf_hit = pf; fp_unmasked = fp;
    c = ref_fault(why);
    exp_have = 1'b1;
    exp_rsp  = v;
    exp_vec  = (v && c >= 0) ? 6'(1 << c) : 6'd0;
    exp_tag  = !v ? "R1" : (tag != "" ? tag : why);
  endtask

  // Clean enabled request with the given memory and fp situation.
  task automatic mreq(input string tag, input logic [1:0] md, input logic mu,
                      input logic [63:0] ad, input logic st, input logic sl,
                      input logic pf, input logic fp, input logic xe);
    step(tag, 1, 0, 0, 1, xe, 1, 0, md, mu, ad, st, sl, pf, fp);
  endtask

  localparam logic [63:0] A_OK    = 64'h0000_0000_0000_1000;
  localparam logic [63:0] A_MIS   = 64'h0000_0000_0000_1008;
  localparam logic [63:0] A_CHI   = 64'h0000_7FFF_FFFF_FFF0;
  localparam logic [63:0] A_CBAD  = 64'h0000_8000_0000_0000;
  localparam logic [63:0] A_CNEG  = 64'hFFFF_8000_0000_0000;
  localparam logic [63:0] A_CNEGB = 64'hFFFF_7FFF_FFFF_FFF0;

  initial begin
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (rsp_vld !== 1'b0 || flt_vld !== 1'b0 || flt_vec !== 6'd0) begin
        errors++;
        $display("FAIL R1 reset actual rsp=%b vld=%b vec=%b expected 0 0 000000",
                 rsp_vld, flt_vld, flt_vec);
      end
    end
    rst_n = 1'b1;

    // R1 idle, R2 clean request
    step("R1", 0, 1, 1, 0, 0, 0, 1, 2, 1, A_CBAD, 1, 1, 1, 1);
    mreq("R2", 1, 1, A_OK, 0, 0, 0, 0, 1);
    // R3 each enable cause, stacked on everything lower
    step("R3", 1, 1, 0, 1, 1, 1, 1, 2, 1, A_CBAD, 1, 1, 1, 1);
    step("R3", 1, 1, 1, 1, 1, 1, 0, 1, 1, A_MIS, 1, 1, 1, 1);
    step("R3", 1, 1, 0, 0, 1, 1, 0, 0, 1, A_MIS, 0, 0, 0, 1);
    step("R3", 1, 0, 0, 1, 1, 0, 0, 3, 0, A_OK, 0, 0, 0, 0);
    // R4 over memory and fp
    step("R4", 1, 1, 0, 1, 1, 1, 0, 2, 1, A_CBAD, 1, 0, 1, 1);
    // R9 stack address fault on a misaligned address, with page and fp too
    mreq("R9", 1, 1, A_MIS, 1, 1, 1, 1, 1);
    mreq("R9", 2, 1, A_CBAD | 64'h8, 1, 0, 1, 1, 1);
    // R7 general-protection variant, canonical ignored
    mreq("R7", 3, 1, A_OK, 0, 1, 1, 1, 1);
    mreq("R7", 1, 1, A_CBAD, 1, 0, 0, 0, 1);
    // R5 misalignment in each mode
    mreq("R5", 0, 1, A_MIS, 1, 1, 1, 1, 1);
    mreq("R5", 1, 1, 64'h0000_0000_0000_2001, 1, 0, 1, 0, 1);
    mreq("R5", 2, 1, A_CHI | 64'hF, 1, 1, 1, 1, 1);
    // R8 canonical boundaries
    mreq("R8", 2, 1, A_CHI, 1, 1, 0, 0, 1);
    mreq("R8", 2, 1, A_CBAD, 1, 1, 0, 0, 1);
    mreq("R8", 2, 1, A_CBAD, 0, 0, 0, 0, 1);
    mreq("R8", 2, 1, A_CNEG, 0, 0, 0, 0, 1);
    mreq("R8", 2, 1, A_CNEGB, 1, 0, 0, 0, 1);
    // R6 real mode edge and ignored inputs
    mreq("R6", 0, 1, 64'hFFFF_FFFF_0000_FFF0, 1, 1, 1, 0, 1);
    mreq("R6", 0, 1, 64'h0000_0000_0000_FFF1, 1, 0, 0, 0, 1);
    // R10 page fault below address checks, above fp
    mreq("R10", 1, 1, A_OK, 1, 0, 1, 1, 1);
    mreq("R10", 2, 1, A_CHI, 0, 0, 1, 1, 0);
    // R11 both outcomes
    mreq("R11", 1, 0, A_OK, 0, 0, 0, 1, 1);
    mreq("R11", 2, 0, A_OK, 0, 0, 0, 1, 0);
    // R12 memory inputs ignored without a memory operand
    mreq("R12", 2, 0, A_CBAD | 64'h3, 1, 1, 1, 0, 1);
    mreq("R12", 1, 0, A_MIS, 1, 1, 1, 0, 0);
    step("R1", 0, 0, 0, 1, 1, 1, 0, 1, 1, A_MIS, 0, 0, 0, 0);

    // Biased random mix
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] ad;
      case ($urandom_range(0, 6))
        0: ad = A_OK;
        1: ad = A_MIS;
        2: ad = A_CBAD;
        3: ad = A_CNEG;
        4: ad = {48'h0, 16'hFFF0 + 16'($urandom_range(0, 15))};
        5: ad = {$urandom(), $urandom()};
        default: ad = {32'h0, $urandom()} & ~64'hF;
      endcase
      step("", $urandom_range(0, 7) != 0,
           $urandom_range(0, 9) == 0, $urandom_range(0, 14) == 0,
           $urandom_range(0, 14) != 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 14) != 0, $urandom_range(0, 14) == 0,
           2'($urandom_range(0, 3)), $urandom_range(0, 2) != 0, ad,
           $urandom_range(0, 1) == 1, $urandom_range(0, 4) == 0,
           $urandom_range(0, 4) == 0, $urandom_range(0, 2) == 0);
    end
    step("R1", 0, 0, 0, 1, 1, 1, 0, 1, 0, A_OK, 0, 0, 0, 0);
    @(negedge clk);
    compare_prev();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule